// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one private cache coherent with its peers on a shared snooping bus. It tracks a four-state MESI code for each line of a direct-mapped tag store: Invalid, Shared, Exclusive and Modified. It serves two kinds of events. Processor reads and writes may finish at once or may need a bus transaction. Transactions that other caches place on the bus are snooped, and the controller answers them in the same cycle. Data contents are held elsewhere. This block decides states, bus commands and which cache drives data.

The tag store is kept in two copies. The processor side looks up one copy and the snoop side looks up the other, so a snoop never takes the processor's lookup port. A processor request is held back only when a snoop targets the same index in the same cycle. A Modified victim moves into a one-entry writeback buffer. Snoops compare against that buffer while the writeback waits for the bus, so a dirty line never drops out of sight.

Bus commands are 2-bit codes: read-for-share 0, read-for-ownership 1, upgrade 2, writeback 3. A transaction takes place in the cycle where `bus_req_o` and `bus_gnt_i` are both high. `bus_shared_i` is the wired-OR of the peers' hit outputs and is sampled in that cycle. `peer_hit_i` carries every cache's hit output, indexed by cache id. Line addresses index the cache by their low `IDX_W` bits and use the remaining bits as the tag.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req_o` and `cpu_done_o` are low, `cpu_ready_o` is high, and no snoop hits.
- R2: A read that hits any valid state, or a write that hits Exclusive or Modified, completes with `cpu_done_o` high one cycle after acceptance and raises no bus request. A write to an Exclusive line makes it Modified.
- R3: A read miss requests command 0 at the line address. At the grant cycle the line fills Exclusive if `bus_shared_i` is low and Shared if it is high. `cpu_done_o` rises one cycle after the grant.
- R4: A write to a Shared line requests command 2 (upgrade) and a write miss requests command 1. Either leaves the line Modified after the grant. If a snoop invalidates the Shared copy while the upgrade waits, the pending request changes to command 1.
- R5: A snooped command 0 that hits a Modified line raises `snp_flush_o` in the same cycle. A hit on Modified or Exclusive leaves the line Shared.
- R6: A snooped command 1 or 2 that hits a valid line invalidates it. A Modified line also raises `snp_flush_o`.
- R7: `snp_hit_o` is high in the snoop cycle when a command 0, 1 or 2 matches a valid line. A snooped command 3 never hits and changes no state.
- R8: `snp_supply_o` is high for a command 0 or 1 that hits an Exclusive or Shared line, but only when no cache with a lower id asserts its `peer_hit_i` bit.
- R9: A miss whose victim is Modified first requests command 3 with the victim's address and then requests the fill. An Exclusive or Shared victim is dropped without a bus transaction.
- R10: A snooped command 0, 1 or 2 that matches the address in the writeback buffer raises `snp_flush_o`. The writeback is then cancelled and the fill request follows at once.
- R11: `cpu_ready_o` is low while a request is in progress, and also in any cycle where a valid snoop has the same index as `cpu_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request valid |
| cpu_we_i | input | 1 | Processor request is a write |
| cpu_addr_i | input | ADDR_W | Processor line address |
| cpu_ready_o | output | 1 | Request accepted this cycle when high |
| cpu_done_o | output | 1 | Request completed (one-cycle pulse) |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_cmd_o | output | 2 | Requested command code |
| bus_addr_o | output | ADDR_W | Requested line address |
| bus_gnt_i | input | 1 | Bus grant; transaction occurs this cycle |
| bus_shared_i | input | 1 | Wired-OR of peer hits during the grant |
| snp_valid_i | input | 1 | Snooped transaction valid |
| snp_cmd_i | input | 2 | Snooped command code |
| snp_addr_i | input | ADDR_W | Snooped line address |
| peer_hit_i | input | NUM_CACHES | Hit outputs of all caches, by id |
| snp_hit_o | output | 1 | Snoop matches a valid local line |
| snp_flush_o | output | 1 | This cache drives dirty data |
| snp_supply_o | output | 1 | This cache drives clean data |

## Verification
The assertions take three things for granted. A grant never arrives in a cycle with a snooped transaction, because the bus carries one transaction at a time. No cache snoops its own request. An upgrade is never snooped while this cache holds the line Modified. The bench drives snoops only while its own request is waiting and not granted. It never grants and snoops in the same cycle, and it issues an upgrade only against lines that its model holds Shared or Invalid.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_st_e;
  typedef enum logic [1:0] {CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_UPGR = 2'd2, CMD_WB = 2'd3} bus_cmd_e;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_WB = 2'd1, F_REQ = 2'd2} req_fsm_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] pr_idx_i,
  output logic [TAG_W-1:0] pr_tag_o,
  output mesi_st_e         pr_st_o,
  input  logic [IDX_W-1:0] sn_idx_i,
  output logic [TAG_W-1:0] sn_tag_o,
  output mesi_st_e         sn_st_o,
  input  logic             pw_en_i,
  input  logic [IDX_W-1:0] pw_idx_i,
  input  logic [TAG_W-1:0] pw_tag_i,
  input  mesi_st_e         pw_st_i,
  input  logic             sw_en_i,
  input  mesi_st_e         sw_st_i
);
  localparam int LINES = 1 << IDX_W;

  mesi_st_e [LINES-1:0]   st_q;
  logic [LINES-1:0][TAG_W-1:0] pr_tag_q;
  logic [LINES-1:0][TAG_W-1:0] sn_tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= '{default: ST_I};
      pr_tag_q <= '0;
      sn_tag_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        // snoop side wins if both touch one index
        if (sw_en_i && sn_idx_i == IDX_W'(i)) st_q[i] <= sw_st_i;
        else if (pw_en_i && pw_idx_i == IDX_W'(i)) st_q[i] <= pw_st_i;
        if (pw_en_i && pw_idx_i == IDX_W'(i)) begin
          pr_tag_q[i] <= pw_tag_i;
          sn_tag_q[i] <= pw_tag_i;
        end
      end
    end
  end

  assign pr_tag_o = pr_tag_q[pr_idx_i];
  assign pr_st_o  = st_q[pr_idx_i];
  assign sn_tag_o = sn_tag_q[sn_idx_i];
  assign sn_st_o  = st_q[sn_idx_i];
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int IDX_W      = 4,
  parameter int NUM_CACHES = 4,
  parameter int CACHE_ID   = 0
) (
  input  logic                  valid_i,
  input  bus_cmd_e              cmd_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [ADDR_W-IDX_W-1:0] line_tag_i,
  input  mesi_st_e              line_st_i,
  input  logic                  wb_valid_i,
  input  logic [ADDR_W-1:0]     wb_addr_i,
  input  logic [NUM_CACHES-1:0] peer_hit_i,
  output logic                  hit_o,
  output logic                  flush_o,
  output logic                  supply_o,
  output logic                  buf_hit_o,
  output logic                  upd_en_o,
  output mesi_st_e              upd_st_o
);
  logic active, lower_hit;

  assign active = valid_i && cmd_i != CMD_WB;

  always_comb begin
    lower_hit = 1'b0;
    for (int j = 0; j < NUM_CACHES; j++)
      if (j < CACHE_ID) lower_hit = lower_hit | peer_hit_i[j];
  end

  assign hit_o     = active && line_st_i != ST_I && line_tag_i == addr_i[ADDR_W-1:IDX_W];
  assign buf_hit_o = active && wb_valid_i && wb_addr_i == addr_i;
  assign flush_o   = (hit_o && line_st_i == ST_M) || buf_hit_o;
  assign supply_o  = hit_o && (line_st_i == ST_E || line_st_i == ST_S) &&
                     cmd_i != CMD_UPGR && !lower_hit;
  assign upd_en_o  = hit_o;
  assign upd_st_o  = (cmd_i == CMD_RD) ? ST_S : ST_I;
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cpu_req_i,
  input  logic                    cpu_we_i,
  input  logic [ADDR_W-1:0]       cpu_addr_i,
  input  logic                    snp_block_i,
  output logic                    ready_o,
  output logic                    done_o,
  output logic [IDX_W-1:0]        look_idx_o,
  input  logic [ADDR_W-IDX_W-1:0] look_tag_i,
  input  mesi_st_e                look_st_i,
  output logic                    bus_req_o,
  output bus_cmd_e                bus_cmd_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  input  logic                    bus_gnt_i,
  input  logic                    bus_shared_i,
  input  logic                    buf_hit_i,
  output logic                    wb_valid_o,
  output logic [ADDR_W-1:0]       wb_addr_o,
  output logic                    pw_en_o,
  output logic [ADDR_W-IDX_W-1:0] pw_tag_o,
  output mesi_st_e                pw_st_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  req_fsm_e          fsm_q, fsm_d;
  logic [ADDR_W-1:0] req_addr_q, wb_addr_q, look_addr;
  logic              req_we_q, wb_valid_q, done_q, done_d, accept, look_hit, wb_set;

  assign look_addr  = (fsm_q == F_IDLE) ? cpu_addr_i : req_addr_q;
  assign look_idx_o = look_addr[IDX_W-1:0];
  assign look_hit   = look_st_i != ST_I && look_tag_i == look_addr[ADDR_W-1:IDX_W];
  assign ready_o    = fsm_q == F_IDLE && !snp_block_i;
  assign accept     = ready_o && cpu_req_i;

  always_comb begin
    fsm_d    = fsm_q;
    done_d   = 1'b0;
    wb_set   = 1'b0;
    pw_en_o  = 1'b0;
    pw_tag_o = look_addr[ADDR_W-1:IDX_W];
    pw_st_o  = ST_I;
    unique case (fsm_q)
      F_IDLE: if (accept) begin
        if (look_hit && (!cpu_we_i || look_st_i != ST_S)) begin
          done_d  = 1'b1;
          pw_en_o = cpu_we_i;
          pw_st_o = ST_M;
        end else if (!look_hit && look_st_i == ST_M) begin
          // dirty victim leaves the array for the writeback buffer
          pw_en_o  = 1'b1;
          pw_tag_o = look_tag_i;
          wb_set   = 1'b1;
          fsm_d    = F_WB;
        end else begin
          fsm_d = F_REQ;
        end
      end
      F_WB: if (buf_hit_i || bus_gnt_i) fsm_d = F_REQ;
      F_REQ: if (bus_gnt_i) begin
        pw_en_o = 1'b1;
        pw_st_o = req_we_q ? ST_M : (bus_shared_i ? ST_S : ST_E);
        done_d  = 1'b1;
        fsm_d   = F_IDLE;
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q      <= F_IDLE;
      req_addr_q <= '0;
      req_we_q   <= 1'b0;
      wb_valid_q <= 1'b0;
      wb_addr_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      done_q <= done_d;
      if (accept) begin
        req_addr_q <= cpu_addr_i;
        req_we_q   <= cpu_we_i;
      end
      if (wb_set) begin
        wb_valid_q <= 1'b1;
        wb_addr_q  <= {look_tag_i, look_addr[IDX_W-1:0]};
      end else if (fsm_q == F_WB && fsm_d != F_WB) begin
        wb_valid_q <= 1'b0;
      end
    end
  end

  assign bus_req_o  = fsm_q != F_IDLE;
  assign bus_cmd_o  = (fsm_q == F_WB) ? CMD_WB :
                      !req_we_q ? CMD_RD :
                      (look_hit && look_st_i == ST_S) ? CMD_UPGR : CMD_RDX;
  assign bus_addr_o = (fsm_q == F_WB) ? wb_addr_q : req_addr_q;
  assign wb_valid_o = wb_valid_q;
  assign wb_addr_o  = wb_addr_q;
  assign done_o     = done_q;

  logic unused_tag_w;
  assign unused_tag_w = ^TAG_W;
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int IDX_W      = 4,
  parameter int NUM_CACHES = 4,
  parameter int CACHE_ID   = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_req_i,
  input  logic                  cpu_we_i,
  input  logic [ADDR_W-1:0]     cpu_addr_i,
  output logic                  cpu_ready_o,
  output logic                  cpu_done_o,
  output logic                  bus_req_o,
  output logic [1:0]            bus_cmd_o,
  output logic [ADDR_W-1:0]     bus_addr_o,
  input  logic                  bus_gnt_i,
  input  logic                  bus_shared_i,
  input  logic                  snp_valid_i,
  input  logic [1:0]            snp_cmd_i,
  input  logic [ADDR_W-1:0]     snp_addr_i,
  input  logic [NUM_CACHES-1:0] peer_hit_i,
  output logic                  snp_hit_o,
  output logic                  snp_flush_o,
  output logic                  snp_supply_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag, sn_tag, pw_tag;
  mesi_st_e          look_st, sn_st, pw_st, sw_st;
  bus_cmd_e          cmd;
  logic              pw_en, sw_en, buf_hit, wb_valid, snp_block, snp_hit, snp_flush, snp_supply;
  logic [ADDR_W-1:0] wb_addr;

  assign snp_block = snp_valid_i && snp_addr_i[IDX_W-1:0] == cpu_addr_i[IDX_W-1:0];

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni,
    .pr_idx_i (look_idx), .pr_tag_o (look_tag), .pr_st_o (look_st),
    .sn_idx_i (snp_addr_i[IDX_W-1:0]), .sn_tag_o (sn_tag), .sn_st_o (sn_st),
    .pw_en_i  (pw_en), .pw_idx_i (look_idx), .pw_tag_i (pw_tag), .pw_st_i (pw_st),
    .sw_en_i  (sw_en), .sw_st_i (sw_st)
  );

  mesi_snoop_resp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_CACHES(NUM_CACHES),
                    .CACHE_ID(CACHE_ID)) u_snoop (
    .valid_i    (snp_valid_i),
    .cmd_i      (bus_cmd_e'(snp_cmd_i)),
    .addr_i     (snp_addr_i),
    .line_tag_i (sn_tag),
    .line_st_i  (sn_st),
    .wb_valid_i (wb_valid),
    .wb_addr_i  (wb_addr),
    .peer_hit_i (peer_hit_i),
    .hit_o      (snp_hit),
    .flush_o    (snp_flush),
    .supply_o   (snp_supply),
    .buf_hit_o  (buf_hit),
    .upd_en_o   (sw_en),
    .upd_st_o   (sw_st)
  );

  mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_we_i, .cpu_addr_i,
    .snp_block_i  (snp_block),
    .ready_o      (cpu_ready_o),
    .done_o       (cpu_done_o),
    .look_idx_o   (look_idx),
    .look_tag_i   (look_tag),
    .look_st_i    (look_st),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (cmd),
    .bus_addr_o   (bus_addr_o),
    .bus_gnt_i, .bus_shared_i,
    .buf_hit_i    (buf_hit),
    .wb_valid_o   (wb_valid),
    .wb_addr_o    (wb_addr),
    .pw_en_o      (pw_en),
    .pw_tag_o     (pw_tag),
    .pw_st_o      (pw_st)
  );

  assign bus_cmd_o    = cmd;
  assign snp_hit_o    = snp_hit;
  assign snp_flush_o  = snp_flush;
  assign snp_supply_o = snp_supply;
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpu_ready_o,
  input logic       cpu_done_o,
  input logic       bus_req_o,
  input logic [1:0] bus_cmd_o,
  input logic       bus_gnt_i,
  input logic       snp_valid_i,
  input logic [1:0] snp_cmd_i,
  input logic       snp_hit_o,
  input logic       snp_flush_o,
  input logic       snp_supply_o
);
  // R3: a granted fill completes on the next cycle
  a_r3_fill_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i && bus_cmd_o != 2'd3 |=> cpu_done_o);

  // R9: a granted writeback is followed by the fill request
  a_r9_wb_then_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i && bus_cmd_o == 2'd3 |=> bus_req_o && bus_cmd_o != 2'd3);

  // R10: a request is held until granted (a cancelled writeback turns into the fill)
  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o);

  // R11: no new request is accepted while one is outstanding
  a_r11_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> !bus_req_o);

  // R7: snooped writebacks never hit nor pull data
  a_r7_wb_snoop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_cmd_i == 2'd3 |-> !snp_hit_o && !snp_supply_o);

  // R8: clean supply and dirty flush never together
  a_r8_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snp_supply_o && snp_flush_o));

  // R6: data only flows for a live snoop
  a_r6_flush_needs_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |-> snp_valid_i);
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_ready_o  (cpu_ready_o),
  .cpu_done_o   (cpu_done_o),
  .bus_req_o    (bus_req_o),
  .bus_cmd_o    (bus_cmd_o),
  .bus_gnt_i    (bus_gnt_i),
  .snp_valid_i  (snp_valid_i),
  .snp_cmd_i    (snp_cmd_i),
  .snp_hit_o    (snp_hit_o),
  .snp_flush_o  (snp_flush_o),
  .snp_supply_o (snp_supply_o)
);

// File: tb/mesi_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb_top;
  localparam int AW = 12;
  localparam int IW = 3;
  localparam int NC = 4;
  localparam int MY_ID = 1;
  localparam int SI = 0, SS = 1, SE = 2, SM = 3;
  localparam int C_RD = 0, C_RDX = 1, C_UPGR = 2, C_WB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_ready, cpu_done, bus_req;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic          bus_gnt = 1'b0, bus_shared = 1'b0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic [NC-1:0] peer_hit = '0;
  logic          snp_hit, snp_flush, snp_supply;

  int n_chk = 0, n_fail = 0;
  int m_tag[8], m_st[8];
  int wb_v = 0, wb_a = 0;
  int pend_en = 0, pend_idx = 0, pend_st = 0, pend_buf = 0;

  always #2.5 clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .NUM_CACHES(NC), .CACHE_ID(MY_ID)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_ready_o(cpu_ready), .cpu_done_o(cpu_done),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_gnt_i(bus_gnt), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .peer_hit_i(peer_hit),
    .snp_hit_o(snp_hit), .snp_flush_o(snp_flush), .snp_supply_o(snp_supply)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  function automatic int m_match(input int a);
    return (m_st[a % 8] != SI && m_tag[a % 8] == a / 8) ? 1 : 0;
  endfunction

  // expected snoop response from the model; records the pending update
  task automatic snoop_check(input int cmd, input int a, input int peers, input string rq);
    int h, f, s, b, st;
    st = m_st[a % 8];
    h  = (cmd != C_WB && m_match(a) == 1) ? 1 : 0;
    b  = (cmd != C_WB && wb_v == 1 && wb_a == a) ? 1 : 0;
    f  = ((h == 1 && st == SM) || b == 1) ? 1 : 0;
    s  = (h == 1 && (st == SE || st == SS) && cmd != C_UPGR && peers[0] == 0) ? 1 : 0;
    chk({rq, " snp_hit"}, int'(snp_hit), h);
    chk({rq, " snp_flush"}, int'(snp_flush), f);
    chk({rq, " snp_supply"}, int'(snp_supply), s);
    pend_en  = h;
    pend_idx = a % 8;
    pend_st  = (cmd == C_RD) ? SS : SI;
    pend_buf = b;
  endtask

  task automatic snoop_apply();
    if (pend_en == 1) m_st[pend_idx] = pend_st;
    if (pend_buf == 1) wb_v = 0;
    pend_en = 0;
    pend_buf = 0;
  endtask

  task automatic snoop(input int cmd, input int a, input int peers, input string rq);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = AW'(a); peer_hit = NC'(peers);
    #1 snoop_check(cmd, a, peers, rq);
    @(posedge clk);
    snoop_apply();
    @(negedge clk);
    snp_valid = 1'b0; peer_hit = '0;
    #1 chk({rq, " no done after snoop"}, int'(cpu_done), 0);
  endtask

  task automatic cpu_op(input int we, input int a, input int shared, input int wait_n,
                        input int inj, input int icmd, input int iaddr, input string rq);
    int idx, hit, st, ph, cnt, first, fin, g, ecmd, eaddr, di;
    idx = a % 8;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'(we); cpu_addr = AW'(a);
    #1 chk({rq, " ready"}, int'(cpu_ready), 1);
    hit = m_match(a);
    st  = m_st[idx];
    @(posedge clk);
    if (hit == 1 && (we == 0 || st != SS)) begin
      if (we == 1) m_st[idx] = SM;
      @(negedge clk);
      cpu_req = 1'b0;
      #1 chk({rq, " hit done"}, int'(cpu_done), 1);
      chk({rq, " hit no bus"}, int'(bus_req), 0);
      return;
    end
    if (hit == 0 && st == SM) begin
      wb_v = 1; wb_a = m_tag[idx] * 8 + idx; m_st[idx] = SI; ph = 1;
    end else ph = 2;
    cnt = wait_n; first = 1; fin = 0;
    while (fin == 0) begin
      @(negedge clk);
      cpu_req = 1'b0;
      di = (first == 1 && inj == 1) ? 1 : 0;
      snp_valid = 1'(di); snp_cmd = 2'(icmd); snp_addr = AW'(iaddr); peer_hit = '0;
      g = (di == 0 && (ph == 1 || cnt == 0)) ? 1 : 0;
      bus_gnt = 1'(g); bus_shared = 1'(shared);
      if (ph == 1) begin ecmd = C_WB; eaddr = wb_a; end
      else begin
        eaddr = a;
        if (we == 0) ecmd = C_RD;
        else if (m_match(a) == 1 && m_st[idx] == SS) ecmd = C_UPGR;
        else ecmd = C_RDX;
      end
      #1;
      chk({rq, " done low while waiting"}, int'(cpu_done), 0);
      chk({rq, " bus_req"}, int'(bus_req), 1);
      chk({rq, " bus_cmd"}, int'(bus_cmd), ecmd);
      chk({rq, " bus_addr"}, int'(bus_addr), eaddr);
      chk({rq, " ready low while busy (R11)"}, int'(cpu_ready), 0);
      if (di == 1) snoop_check(icmd, iaddr, 0, rq);
      @(posedge clk);
      if (di == 1) begin
        snoop_apply();
        if (ph == 1 && wb_v == 0) ph = 2;
      end else if (g == 1) begin
        if (ph == 1) begin wb_v = 0; ph = 2; end
        else begin
          m_tag[idx] = a / 8;
          m_st[idx]  = (we == 1) ? SM : ((shared == 1) ? SS : SE);
          fin = 1;
        end
      end else if (ph == 2) cnt--;
      first = 0;
    end
    @(negedge clk);
    bus_gnt = 1'b0; snp_valid = 1'b0; bus_shared = 1'b0;
    #1 chk({rq, " done after grant"}, int'(cpu_done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_tag[i] = 0; m_st[i] = SI; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 reset bus_req", int'(bus_req), 0);
    chk("R1 reset done", int'(cpu_done), 0);
    chk("R1 reset ready", int'(cpu_ready), 1);
    snoop(C_RD, 'h010, 0, "R1 no hit after reset");

    // R3 read miss, no sharer -> E; R2 silent E->M write
    cpu_op(0, 'h010, 0, 2, 0, 0, 0, "R3 read miss fill E");
    cpu_op(1, 'h010, 0, 0, 0, 0, 0, "R2 write E silent");
    cpu_op(0, 'h010, 0, 0, 0, 0, 0, "R2 read hit M");
    snoop(C_RD, 'h010, 0, "R5 snoop read on M");
    cpu_op(0, 'h010, 0, 0, 0, 0, 0, "R2 read hit S");
    cpu_op(1, 'h010, 0, 1, 0, 0, 0, "R4 upgrade from S");
    snoop(C_RDX, 'h010, 0, "R6 snoop rdx on M");
    snoop(C_RD, 'h010, 0, "R6 line gone");

    // R3 shared fill, R8 supply priority, R7 writeback snoop ignored
    cpu_op(0, 'h021, 1, 0, 0, 0, 0, "R3 read miss fill S");
    snoop(C_RD, 'h021, 'b0001, "R8 lower peer holds");
    snoop(C_RD, 'h021, 'b0100, "R8 only higher peer");
    snoop(C_WB, 'h021, 0, "R7 writeback snoop ignored");
    snoop(C_RD, 'h021, 0, "R7 line kept after writeback snoop");
    snoop(C_UPGR, 'h021, 0, "R6 snoop upgrade on S");
    snoop(C_RD, 'h021, 0, "R6 line gone after upgrade");

    // R9 dirty victim writeback, then silent victim
    cpu_op(0, 'h012, 0, 0, 0, 0, 0, "R3 fill C");
    cpu_op(1, 'h012, 0, 0, 0, 0, 0, "R2 dirty C");
    cpu_op(0, 'h022, 0, 1, 0, 0, 0, "R9 dirty victim");
    snoop(C_RD, 'h012, 0, "R9 victim gone");
    snoop(C_RD, 'h022, 'b0001, "R5 snoop read on E");
    cpu_op(0, 'h032, 0, 0, 0, 0, 0, "R9 silent victim");

    // R10 snoop hits the pending writeback
    cpu_op(1, 'h013, 0, 0, 0, 0, 0, "R4 write miss rdx");
    cpu_op(0, 'h023, 0, 0, 1, C_RDX, 'h013, "R10 buffered writeback snooped");
    snoop(C_RD, 'h013, 0, "R10 no stale copy");

    // R4 upgrade lost to a peer write while waiting
    cpu_op(0, 'h014, 1, 0, 0, 0, 0, "R3 fill H shared");
    cpu_op(1, 'h014, 0, 1, 1, C_RDX, 'h014, "R4 upgrade becomes rdx");
    snoop(C_RD, 'h014, 0, "R5 rd on M after rdx fill");

    // R11 same-index snoop blocks the processor
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 'h015;
    snp_valid = 1'b1; snp_cmd = 2'(C_RD); snp_addr = 'h035; peer_hit = '0;
    #1 chk("R11 ready low on same-index snoop", int'(cpu_ready), 0);
    snoop_check(C_RD, 'h035, 0, "R11 same-index snoop");
    @(posedge clk);
    snoop_apply();
    @(negedge clk);
    cpu_req = 1'b0; cpu_addr = 'h016; snp_addr = 'h035;
    #1 chk("R11 request not taken", int'(cpu_done), 0);
    chk("R11 request not taken bus", int'(bus_req), 0);
    chk("R11 ready high on other-index snoop", int'(cpu_ready), 1);
    @(posedge clk);
    snoop_apply();
    @(negedge clk);
    snp_valid = 1'b0;
    snoop(C_RD, 'h015, 0, "R11 blocked request left no line");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule